// File: doc/BRIEF.md
# Dual-View SIMD Register File

This block is the register storage for a 64/128-bit SIMD unit. One array of flops can be reached in two ways. The doubleword view has 32 registers of 64 bits. The quadword view has 16 registers of 128 bits. Each quadword register sits on top of a pair of doublewords, so data written through either view is seen at once through the other. Integer elements and single-precision floating-point elements share these registers, and the block treats every register as raw bits.

The block has two independent read ports and one write port. Each port has its own view select and register number. A write can be limited to chosen elements of 8, 16, 32 or 64 bits through a lane-enable mask. Reads are combinational and see the write of the same cycle (write-first), so an execution pipeline can read an operand in the cycle it is written back.

The reset input is asserted asynchronously. Its release reaches the storage through a two-stage synchronizer.

Top module: `simd_alias_rf`

## Requirements
- R1: After reset every doubleword register reads as zero through both views.
- R2: A doubleword read (view select 0) of register i in 0..31 returns D(i) in bits 63:0, and bits 127:64 read as zero.
- R3: A quadword read (view select 1) of register n returns D(2n+1) in bits 127:64 and D(2n) in bits 63:0. Index bit 4 is ignored in this view, for reads and for writes.
- R4: Data written through one view is read back unchanged through the other view after the write's clock edge.
- R5: The element size code is 00=8, 01=16, 10=32 and 11=64 bits. Lane-enable bit k covers bits [k*E +: E] of the write data vector, where E is the element size.
- R6: Bits in disabled lanes keep their old value. In a doubleword write, lanes that lie above bit 63 of the data vector are ignored.
- R7: A quadword write updates both of its doubleword halves at the same clock edge. The low half takes data bits 63:0 and the high half takes data bits 127:64.
- R8: A read of a register that is being written in the same cycle returns the merged new value. This includes a quadword read that covers a doubleword being written.
- R9: When write enable is low, no register changes, whatever the other write inputs are.
- R10: The two read ports work independently, each with its own view and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_quad | input | 1 | Write view: 0 doubleword, 1 quadword |
| wr_idx | input | 5 | Write register number |
| wr_size | input | 2 | Element size code |
| wr_lane_en | input | 16 | Per-element write enable |
| wr_data | input | 128 | Write data vector |
| ra_quad | input | 1 | Read port A view |
| ra_idx | input | 5 | Read port A register number |
| ra_data | output | 128 | Read port A data |
| rb_quad | input | 1 | Read port B view |
| rb_idx | input | 5 | Read port B register number |
| rb_data | output | 128 | Read port B data |

## Verification
A wrong byte enable or a wrong row selection leaves the wrong bits in storage. Because reads are combinational and write-first, the bad value shows on a read port in the same cycle as the faulty write, and a read through the other view shows it again in the next cycle. The bench checks both read ports in every cycle against a reference model of the 32 doublewords. A corruption is therefore reported no later than the first later read of the affected register. Directed cases cover pairs of views that overlap, lanes above the doubleword width, writes with enable low, and index bit 4 in the quadword view.

// File: rtl/simd_rf_pkg.sv
package simd_rf_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } esize_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/simd_rf_byte_en.sv
module simd_rf_byte_en #(
  parameter int unsigned NBYTES = 16
) (
  input  logic [1:0]        size,
  input  logic [NBYTES-1:0] lanes,
  output logic [NBYTES-1:0] be
);
  always_comb begin
    for (int b = 0; b < NBYTES; b++) begin
      be[b] = lanes[b >> size];
    end
  end

  // Each enabled lane must open exactly 2**size bytes.
  logic [$clog2(NBYTES):0] lane_cnt;
  always_comb begin
    lane_cnt = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (k < (NBYTES >> size)) lane_cnt = lane_cnt + {{$clog2(NBYTES){1'b0}}, lanes[k]};
    end
    assert_byte_count_R5: assert ($countones(be) == (32'(lane_cnt) << size))
      else $error("byte enable count does not match lane count");
  end
endmodule

// File: rtl/simd_rf_row.sv
module simd_rf_row
  import simd_rf_pkg::*;
#(
  parameter int unsigned DW = 64,
  localparam int unsigned NB = DW / BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [NB-1:0] be,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic [DW-1:0] q_nxt
);
  logic [DW-1:0] bmask;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bmask[b*BYTE_W +: BYTE_W] = {BYTE_W{be[b]}};
    end
    q_nxt = hit ? ((d & bmask) | (q & ~bmask)) : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (hit) begin
      q <= q_nxt;
    end
  end

  assert_row_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && rst_n) |=> $stable(q));

  assert_masked_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rst_n) |=> (((q ^ $past(q)) & ~$past(bmask)) == '0));

  assert_lane_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && rst_n) |=> ((q & $past(bmask)) == ($past(d) & $past(bmask))));
endmodule

// File: rtl/simd_rf_read_port.sv
module simd_rf_read_port #(
  parameter int unsigned DW = 64,
  parameter int unsigned ND = 32,
  localparam int unsigned IW  = $clog2(ND),
  localparam int unsigned QIW = IW - 1
) (
  input  logic [ND-1:0][DW-1:0] regs,
  input  logic                  quad,
  input  logic [IW-1:0]         idx,
  output logic [2*DW-1:0]       data
);
  always_comb begin
    if (quad) begin
      data = {regs[{idx[QIW-1:0], 1'b1}], regs[{idx[QIW-1:0], 1'b0}]};
    end else begin
      data = {{DW{1'b0}}, regs[idx]};
    end
  end
endmodule

// File: rtl/simd_alias_rf.sv
module simd_alias_rf
  import simd_rf_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned ND = 32,
  localparam int unsigned QW  = 2 * DW,
  localparam int unsigned NBD = DW / BYTE_W,
  localparam int unsigned NBQ = QW / BYTE_W,
  localparam int unsigned IW  = $clog2(ND),
  localparam int unsigned QIW = IW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_quad,
  input  logic [IW-1:0]  wr_idx,
  input  logic [1:0]     wr_size,
  input  logic [NBQ-1:0] wr_lane_en,
  input  logic [QW-1:0]  wr_data,
  input  logic           ra_quad,
  input  logic [IW-1:0]  ra_idx,
  output logic [QW-1:0]  ra_data,
  input  logic           rb_quad,
  input  logic [IW-1:0]  rb_idx,
  output logic [QW-1:0]  rb_data
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  // Byte enables over the full quadword data vector.
  logic [NBQ-1:0] wr_be;

  simd_rf_byte_en #(.NBYTES(NBQ)) u_byte_en (
    .size  (wr_size),
    .lanes (wr_lane_en),
    .be    (wr_be)
  );

  // Write routing: each doubleword row picks its half of the vector.
  logic [ND-1:0]           row_hit;
  logic [ND-1:0][NBD-1:0]  row_be;
  logic [ND-1:0][DW-1:0]   row_d;
  logic [ND-1:0][DW-1:0]   row_q;
  logic [ND-1:0][DW-1:0]   row_nxt;

  always_comb begin
    for (int r = 0; r < ND; r++) begin
      logic upper;
      upper = wr_quad & IW'(r) == {wr_idx[QIW-1:0], 1'b1};
      if (wr_quad) row_hit[r] = wr_en && (QIW'(r >> 1) == wr_idx[QIW-1:0]);
      else         row_hit[r] = wr_en && (IW'(r) == wr_idx);
      row_be[r] = upper ? wr_be[NBQ-1:NBD] : wr_be[NBD-1:0];
      row_d[r]  = upper ? wr_data[QW-1:DW] : wr_data[DW-1:0];
    end
  end

  always_comb begin
    assert_pair_hit_R7: assert (!(wr_en && wr_quad) || $countones(row_hit) == 2)
      else $error("quadword write must select two rows");
    assert_single_hit_R2: assert (!(wr_en && !wr_quad) || $countones(row_hit) == 1)
      else $error("doubleword write must select one row");
    assert_no_hit_R9: assert (wr_en || row_hit == '0)
      else $error("row selected with write disabled");
  end

  for (genvar g = 0; g < ND; g++) begin : g_row
    simd_rf_row #(.DW(DW)) u_row (
      .clk   (clk),
      .rst_n (rst_core_n),
      .hit   (row_hit[g]),
      .be    (row_be[g]),
      .d     (row_d[g]),
      .q     (row_q[g]),
      .q_nxt (row_nxt[g])
    );
  end

  // Both ports read the next-state values: write-first bypass.
  simd_rf_read_port #(.DW(DW), .ND(ND)) u_rd_a (
    .regs (row_nxt),
    .quad (ra_quad),
    .idx  (ra_idx),
    .data (ra_data)
  );

  simd_rf_read_port #(.DW(DW), .ND(ND)) u_rd_b (
    .regs (row_nxt),
    .quad (rb_quad),
    .idx  (rb_idx),
    .data (rb_data)
  );
endmodule

// File: tb/simd_alias_rf_bench.sv
module simd_alias_rf_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en, wr_quad;
  logic [4:0]   wr_idx;
  logic [1:0]   wr_size;
  logic [15:0]  wr_lane_en;
  logic [127:0] wr_data;
  logic         ra_quad, rb_quad;
  logic [4:0]   ra_idx, rb_idx;
  logic [127:0] ra_data, rb_data;

  int checks = 0;
  int errors = 0;

  logic [63:0] mdl [32];
  logic [63:0] nxt_m [32];

  always #10 clk = ~clk;

  simd_alias_rf u_simd_alias_rf (
    .clk, .rst_n, .wr_en, .wr_quad, .wr_idx, .wr_size, .wr_lane_en, .wr_data,
    .ra_quad, .ra_idx, .ra_data, .rb_quad, .rb_idx, .rb_data
  );

  function automatic logic [127:0] exp_read(input logic q, input logic [4:0] i);
    if (q) return {nxt_m[{i[3:0], 1'b1}], nxt_m[{i[3:0], 1'b0}]};
    return {64'b0, nxt_m[i]};
  endfunction

  task automatic build_next();
    for (int r = 0; r < 32; r++) nxt_m[r] = mdl[r];
    if (wr_en) begin
      for (int b = 0; b < 16; b++) begin
        logic en;
        int   row;
        en = wr_lane_en[b >> wr_size];
        if (wr_quad) row = {wr_idx[3:0], b[3]};
        else         row = wr_idx;
        if (en && (wr_quad || b < 8)) nxt_m[row][(b % 8)*8 +: 8] = wr_data[b*8 +: 8];
      end
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic we, input logic wq, input logic [4:0] wi,
                       input logic [1:0] ws, input logic [15:0] wl, input logic [127:0] wd,
                       input logic aq, input logic [4:0] ai, input logic bq, input logic [4:0] bi,
                       input string tag);
    @(negedge clk);
    wr_en = we; wr_quad = wq; wr_idx = wi; wr_size = ws; wr_lane_en = wl; wr_data = wd;
    ra_quad = aq; ra_idx = ai; rb_quad = bq; rb_idx = bi;
    #2;
    build_next();
    chk({tag, " port A"}, ra_data, exp_read(aq, ai));
    chk({tag, " port B"}, rb_data, exp_read(bq, bi));
    @(posedge clk);
    for (int r = 0; r < 32; r++) mdl[r] = nxt_m[r];
  endtask

  task automatic rd(input logic aq, input logic [4:0] ai, input logic bq, input logic [4:0] bi,
                    input string tag);
    cycle(1'b0, 1'b0, 5'd0, 2'd0, 16'h0, 128'h0, aq, ai, bq, bi, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [127:0] PAT_A = 128'hFEDCBA98_76543210_0F1E2D3C_4B5A6978;
  localparam logic [127:0] PAT_B = 128'h11223344_55667788_99AABBCC_DDEEFF00;

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < 32; r++) mdl[r] = '0;
    rst_n = 1'b0;
    wr_en = 0; wr_quad = 0; wr_idx = 0; wr_size = 0; wr_lane_en = 0; wr_data = 0;
    ra_quad = 0; ra_idx = 0; rb_quad = 0; rb_idx = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i++) rd(1'b0, 5'(i), 1'b1, 5'(i % 16), "R1");

    // R8 bypass on quad write; R7 both halves; R4 seen through doubleword view
    cycle(1'b1, 1'b1, 5'd3, 2'b11, 16'h0003, PAT_A, 1'b1, 5'd3, 1'b0, 5'd7, "R8");
    rd(1'b0, 5'd6, 1'b0, 5'd7, "R7");
    rd(1'b0, 5'd6, 1'b1, 5'd3, "R4");

    // R5: byte lanes on a doubleword; R2 upper half zero
    cycle(1'b1, 1'b0, 5'd9, 2'b00, 16'h00A5, PAT_B, 1'b0, 5'd9, 1'b0, 5'd8, "R5");
    rd(1'b0, 5'd9, 1'b1, 5'd4, "R2");
    // R6: lanes above bit 63 in a doubleword write are ignored
    cycle(1'b1, 1'b0, 5'd9, 2'b00, 16'hFF00, PAT_A, 1'b0, 5'd9, 1'b1, 5'd4, "R6");
    // R5: halfword and word lanes on a quadword
    cycle(1'b1, 1'b1, 5'd10, 2'b01, 16'h0025, PAT_B, 1'b1, 5'd10, 1'b0, 5'd21, "R5");
    cycle(1'b1, 1'b1, 5'd10, 2'b10, 16'h0002, PAT_A, 1'b1, 5'd10, 1'b0, 5'd20, "R5");
    // R9: write enable low changes nothing
    cycle(1'b0, 1'b1, 5'd3, 2'b00, 16'hFFFF, PAT_B, 1'b1, 5'd3, 1'b0, 5'd6, "R9");
    rd(1'b1, 5'd3, 1'b1, 5'd10, "R9");
    // R8: quad read covering a doubleword being written
    cycle(1'b1, 1'b0, 5'd9, 2'b11, 16'h0001, PAT_B, 1'b1, 5'd4, 1'b0, 5'd9, "R8");
    // R3: index bit 4 ignored in quadword view
    rd(1'b1, 5'd19, 1'b1, 5'd3, "R3");
    cycle(1'b1, 1'b1, 5'd31, 2'b11, 16'h0003, PAT_B, 1'b1, 5'd15, 1'b0, 5'd31, "R3");
    rd(1'b0, 5'd30, 1'b0, 5'd31, "R3");

    // R10: random traffic on both ports
    for (int n = 0; n < 2000; n++) begin
      cycle(1'($urandom), 1'($urandom), 5'($urandom), 2'($urandom), 16'($urandom),
            {$urandom, $urandom, $urandom, $urandom},
            1'($urandom), 5'($urandom), 1'($urandom), 5'($urandom), "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule